// File: doc/BRIEF.md
# Quadrature Sign-Bit Phase Tracker

This block is a digital phase-locked loop that follows a complex baseband carrier using only two bits per sample: the sign of the in-phase rail and the sign of the quadrature rail. Together these two bits place the incoming phasor in one of four quadrants. Inside the block, a wide phase accumulator advances by a tracked frequency step on every sample. The top two accumulator bits name the quadrant of the local oscillator.

On each sample the block compares the two quadrant codes and sorts the result into one of five classifications. ALIGNED means both codes name the same quadrant. AHEAD means the local quadrant is one quarter-turn counterclockwise of the input. BEHIND means it is one quarter-turn clockwise. OPPOSED_AHEAD and OPPOSED_BEHIND cover a half-turn disagreement, and the accumulator quadrant alone settles which of the two applies.

Every classification other than ALIGNED produces a signed error. That error nudges the phase by a programmable power-of-two correction and nudges the frequency step by a second, smaller power-of-two correction. Either OPPOSED classification pulls the lock flag low.

A demodulator uses the block to follow a carrier whose frequency is only roughly known. It reads the frequency step to obtain the carrier rate, and reads the accumulator to obtain the phase. All state advances only on cycles where the sample strobe is high.

Top module: `qpll_track`

## Requirements
- R1: Input quadrant coding, with a bit value of 1 meaning the rail is non-negative: {I,Q} = 11 is +45 degrees, 01 is +135, 00 is -135 and 10 is -45. Accumulator bits [31:30] = 00, 01, 10 and 11 name those same four angles in that order.
- R2: When the two quadrants match (ALIGNED), the error output is 2'b00 and the lock flag is 1.
- R3: When the accumulator quadrant is one step counterclockwise of the input quadrant (AHEAD), the error output is 2'b11 (-1), the lock flag is 1, and both corrections are subtracted.
- R4: When the accumulator quadrant is one step clockwise of the input quadrant (BEHIND), the error output is 2'b01 (+1), the lock flag is 1, and both corrections are added.
- R5: When the two quadrants are a half-turn apart, the lock flag is 0. If accumulator bits [31:30] are 00 or 01, the result is OPPOSED_AHEAD: error 2'b11 and the corrections are subtracted. If those bits are 10 or 11, the result is OPPOSED_BEHIND: error 2'b01 and the corrections are added.
- R6: On a strobed sample, the new phase equals the old phase plus the old frequency step, modulo 2^32. When an error exists, the new phase also adds or subtracts (1 << phase_shift), for any shift from 0 to 31.
- R7: On a strobed sample with an error, the frequency step changes by plus or minus (1 << freq_shift), modulo 2^32, for any shift from 0 to 31. With no error it is unchanged.
- R8: While the sample strobe is low, the phase, the frequency step, the error and the lock flag all hold their values.
- R9: Reset sets the phase to 0, loads the frequency step from init_step, and drives the error to 2'b00 and the lock flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Marks a cycle that carries a new sample |
| i_sign | input | 1 | In-phase sign bit, 1 means non-negative |
| q_sign | input | 1 | Quadrature sign bit, 1 means non-negative |
| phase_shift | input | 5 | Log2 of the phase correction |
| freq_shift | input | 5 | Log2 of the frequency correction |
| init_step | input | 32 | Frequency step loaded at reset |
| phase_acc | output | 32 | Phase accumulator |
| freq_step | output | 32 | Tracked frequency step |
| err | output | 2 | Signed error: 00 zero, 01 +1, 11 -1 |
| locked | output | 1 | Low on half-turn disagreement |

## Verification
The bench builds the block at its default 32-bit phase width, so the shift ports cover every exponent from 0 through 31. This range includes a correction of 2^31, a half turn, which equals its own negation. One run uses a quarter-turn phase correction. That choice moves the accumulator through all four quadrants in a few samples, so every pairing of input quadrant and accumulator quadrant, including both half-turn tie-breaks, can be reached. A second run tracks a steady tone with idle gaps between samples, which exercises accumulator wrap-around and the hold behaviour.

// File: rtl/qpll_pkg.sv
package qpll_pkg;

    // Quadrant codes, counted counterclockwise starting at +45 degrees
    typedef enum logic [1:0] {
        QD_NE = 2'd0,
        QD_NW = 2'd1,
        QD_SW = 2'd2,
        QD_SE = 2'd3
    } quad_e;

    // Result of comparing the two quadrant codes
    typedef enum logic [2:0] {
        VD_ALIGNED      = 3'd0,
        VD_AHEAD        = 3'd1,
        VD_BEHIND       = 3'd2,
        VD_OPP_AHEAD    = 3'd3,
        VD_OPP_BEHIND   = 3'd4
    } verdict_e;

    localparam logic [1:0] ERR_ZERO = 2'b00;
    localparam logic [1:0] ERR_POS  = 2'b01;
    localparam logic [1:0] ERR_NEG  = 2'b11;

endpackage

// File: rtl/qpll_iq_quadrant.sv
module qpll_iq_quadrant
    import qpll_pkg::*;
(
    input  logic  i_sign,
    input  logic  q_sign,
    output quad_e quad
);

    // R1: sign-bit pair to counterclockwise quadrant index
    always_comb begin
        unique case ({i_sign, q_sign})
            2'b11:   quad = QD_NE;
            2'b01:   quad = QD_NW;
            2'b00:   quad = QD_SW;
            default: quad = QD_SE;
        endcase
    end

endmodule

// File: rtl/qpll_phase_cmp.sv
module qpll_phase_cmp
    import qpll_pkg::*;
(
    input  quad_e    in_quad,
    input  quad_e    acc_quad,
    output verdict_e verdict,
    output logic     has_err,
    output logic     go_down,
    output logic     opposed
);

    logic [1:0] diff;

    always_comb begin
        diff = 2'(acc_quad - in_quad);
        unique case (diff)
            2'd0:    verdict = VD_ALIGNED;
            2'd1:    verdict = VD_AHEAD;
            2'd3:    verdict = VD_BEHIND;
            default: verdict = acc_quad[1] ? VD_OPP_BEHIND : VD_OPP_AHEAD;
        endcase
    end

    always_comb begin
        has_err = 1'b1;
        go_down = 1'b0;
        opposed = 1'b0;
        unique case (verdict)
            VD_ALIGNED:    has_err = 1'b0;
            VD_AHEAD:      go_down = 1'b1;
            VD_BEHIND:     go_down = 1'b0;
            VD_OPP_AHEAD:  begin go_down = 1'b1; opposed = 1'b1; end
            VD_OPP_BEHIND: opposed = 1'b1;
            default:       has_err = 1'b0;
        endcase
    end

    // R5
    always_comb begin
        opposed_err_chk: assert (!opposed || has_err);
    end

endmodule

// File: rtl/qpll_loop_acc.sv
module qpll_loop_acc #(
    parameter int PHASE_W = 32,
    parameter int SHIFT_W = $clog2(PHASE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_en,
    input  logic               has_err,
    input  logic               go_down,
    input  logic [SHIFT_W-1:0] phase_shift,
    input  logic [SHIFT_W-1:0] freq_shift,
    input  logic [PHASE_W-1:0] init_step,
    output logic [PHASE_W-1:0] phase_q,
    output logic [PHASE_W-1:0] freq_q
);

    localparam logic [PHASE_W-1:0] UNIT = PHASE_W'(1);

    logic [PHASE_W-1:0] p_corr, f_corr;
    logic [PHASE_W-1:0] phase_d, freq_d;

    always_comb begin
        p_corr = UNIT << phase_shift;
        f_corr = UNIT << freq_shift;
        phase_d = phase_q + freq_q;
        freq_d  = freq_q;
        if (has_err) begin
            if (go_down) begin
                phase_d = phase_d - p_corr;
                freq_d  = freq_q - f_corr;
            end else begin
                phase_d = phase_d + p_corr;
                freq_d  = freq_q + f_corr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            freq_q  <= init_step;
        end else if (sample_en) begin
            phase_q <= phase_d;
            freq_q  <= freq_d;
        end
    end

    // R6
    aligned_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && !has_err |=> phase_q == $past(phase_q) + $past(freq_q));

    // R7
    aligned_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && !has_err |=> freq_q == $past(freq_q));

    // R7
    down_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && has_err && go_down |=> freq_q == $past(freq_q) - (UNIT << $past(freq_shift)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(phase_q) && $stable(freq_q));

endmodule

// File: rtl/qpll_track.sv
module qpll_track
    import qpll_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int SHIFT_W = $clog2(PHASE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sample_en,
    input  logic               i_sign,
    input  logic               q_sign,
    input  logic [SHIFT_W-1:0] phase_shift,
    input  logic [SHIFT_W-1:0] freq_shift,
    input  logic [PHASE_W-1:0] init_step,
    output logic [PHASE_W-1:0] phase_acc,
    output logic [PHASE_W-1:0] freq_step,
    output logic [1:0]         err,
    output logic               locked
);

    quad_e    in_quad, acc_quad;
    verdict_e verdict;
    logic     has_err, go_down, opposed;
    logic     primed;
    logic [1:0] err_d;

    assign acc_quad = quad_e'(phase_acc[PHASE_W-1 -: 2]);

    qpll_iq_quadrant u_iq (
        .i_sign (i_sign),
        .q_sign (q_sign),
        .quad   (in_quad)
    );

    qpll_phase_cmp u_cmp (
        .in_quad  (in_quad),
        .acc_quad (acc_quad),
        .verdict  (verdict),
        .has_err  (has_err),
        .go_down  (go_down),
        .opposed  (opposed)
    );

    qpll_loop_acc #(.PHASE_W(PHASE_W), .SHIFT_W(SHIFT_W)) u_loop (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_en   (sample_en),
        .has_err     (has_err),
        .go_down     (go_down),
        .phase_shift (phase_shift),
        .freq_shift  (freq_shift),
        .init_step   (init_step),
        .phase_q     (phase_acc),
        .freq_q      (freq_step)
    );

    always_comb begin
        if (!has_err)     err_d = ERR_ZERO;
        else if (go_down) err_d = ERR_NEG;
        else              err_d = ERR_POS;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err    <= ERR_ZERO;
            locked <= 1'b0;
            primed <= 1'b0;
        end else if (sample_en) begin
            err    <= err_d;
            locked <= !opposed;
            primed <= 1'b1;
        end
    end

    // R3
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err != 2'b10);

    // R5
    unlock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !locked |-> err != ERR_ZERO);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(err) && $stable(locked));

    // R2
    aligned_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en && verdict == VD_ALIGNED |=> locked && err == ERR_ZERO);

endmodule

// File: tb/qpll_track_test.sv
`timescale 1ns/1ps
module qpll_track_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_en = 1'b0;
    logic        i_sign = 1'b0, q_sign = 1'b0;
    logic [4:0]  phase_shift = '0, freq_shift = '0;
    logic [31:0] init_step = '0;
    logic [31:0] phase_acc, freq_step;
    logic [1:0]  err;
    logic        locked;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] ph;
        logic [31:0] fr;
        logic [1:0]  er;
        logic        lk;
        string       tag;
    } exp_t;

    exp_t sb[$];
    exp_t last;
    bit   have_last = 0;

    logic [31:0] m_phase, m_freq;

    always #2.5 clk = ~clk;

    qpll_track uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .i_sign(i_sign), .q_sign(q_sign),
        .phase_shift(phase_shift), .freq_shift(freq_shift),
        .init_step(init_step),
        .phase_acc(phase_acc), .freq_step(freq_step),
        .err(err), .locked(locked)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        check(phase_acc === e.ph, "R6", "phase", phase_acc, e.ph);
        check(freq_step === e.fr, "R7", "freq", freq_step, e.fr);
        check(err === e.er, e.tag, "err", 32'(err), 32'(e.er));
        check(locked === e.lk, e.tag, "lock", 32'(locked), 32'(e.lk));
    endtask

    // Driver: model from requirements, push expected result, drive one sample
    task automatic apply(input bit iv, input bit qv, input int ps, input int fs);
        int in_idx, acc_idx, diff;
        bit down, errx;
        exp_t e;
        @(negedge clk);
        // R1 coding
        case ({iv, qv})
            2'b11: in_idx = 0;
            2'b01: in_idx = 1;
            2'b00: in_idx = 2;
            default: in_idx = 3;
        endcase
        acc_idx = int'(m_phase[31:30]);
        diff = (acc_idx - in_idx + 4) % 4;
        errx = 1; down = 0; e.lk = 1;
        case (diff)
            0: begin errx = 0; e.tag = "R1+R2"; end
            1: begin down = 1; e.tag = "R1+R3"; end
            3: begin down = 0; e.tag = "R1+R4"; end
            default: begin e.lk = 0; down = (acc_idx < 2); e.tag = "R1+R5"; end
        endcase
        e.er = !errx ? 2'b00 : (down ? 2'b11 : 2'b01);
        m_phase = m_phase + m_freq;
        if (errx) begin
            if (down) begin
                m_phase = m_phase - (32'd1 << ps);
                m_freq  = m_freq  - (32'd1 << fs);
            end else begin
                m_phase = m_phase + (32'd1 << ps);
                m_freq  = m_freq  + (32'd1 << fs);
            end
        end
        e.ph = m_phase; e.fr = m_freq;
        sb.push_back(e);
        i_sign = iv; q_sign = qv;
        phase_shift = 5'(ps); freq_shift = 5'(fs);
        sample_en = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            sample_en = 1'b0;
            i_sign = ~i_sign;
            phase_shift = 5'(k);
        end
    endtask

    task automatic do_reset(input logic [31:0] init);
        @(negedge clk);
        have_last = 0;
        sample_en = 1'b0;
        rst_n = 1'b0;
        init_step = init;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_phase = '0;
        m_freq = init;
        // R9 reset state
        check(phase_acc === 32'd0, "R9", "phase", phase_acc, 32'd0);
        check(freq_step === init, "R9", "freq", freq_step, init);
        check(err === 2'b00, "R9", "err", 32'(err), 32'd0);
        check(locked === 1'b0, "R9", "lock", 32'(locked), 32'd0);
        last.ph = '0; last.fr = init; last.er = 2'b00; last.lk = 1'b0; last.tag = "R8";
        have_last = 1;
    endtask

    // Monitor: compare after each edge; idle cycles must hold (R8)
    initial begin
        forever begin
            bit s_en, s_rst;
            @(posedge clk);
            s_en = sample_en;
            s_rst = rst_n;
            #1;
            if (s_rst && have_last) begin
                if (s_en) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R6", "scoreboard empty", 32'd0, 32'd1);
                    end else begin
                        last = sb.pop_front();
                        compare(last);
                    end
                end else begin
                    check(phase_acc === last.ph, "R8", "hold phase", phase_acc, last.ph);
                    check(freq_step === last.fr, "R8", "hold freq", freq_step, last.fr);
                    check(err === last.er, "R8", "hold err", 32'(err), 32'(last.er));
                    check(locked === last.lk, "R8", "hold lock", 32'(locked), 32'(last.lk));
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] ref_ph;
        do_reset(32'h0000_0000);
        // Quarter-turn phase corrections sweep every quadrant pairing (R2..R5)
        for (int r = 0; r < 6; r++)
            for (int k = 0; k < 4; k++)
                apply(k[1], k[0] ^ r[0], 30, r);
        idle(3);
        // Extreme and mixed shifts, including 31 (R6, R7)
        for (int k = 0; k < 300; k++)
            apply(1'($urandom), 1'($urandom), int'($urandom % 32), int'($urandom % 32));
        apply(1'b0, 1'b0, 31, 31);
        apply(1'b1, 1'b0, 31, 31);
        idle(2);
        // Tone tracking with idle gaps, fresh reset with nonzero step
        do_reset(32'h3000_0000);
        ref_ph = 32'h9000_0000;
        for (int k = 0; k < 3000; k++) begin
            ref_ph = ref_ph + 32'h3120_0000;
            // R1: I non-negative in quadrants at +/-45, Q non-negative in upper half
            apply(ref_ph[31] == ref_ph[30], !ref_ph[31], 24, 14);
            if (k % 37 == 5) idle(1 + k % 3);
        end
        @(negedge clk);
        sample_en = 1'b0;
        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R6", "scoreboard drained", 32'(sb.size()), 32'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule